// File: doc/BRIEF.md
# Flash programming mode bridge

This block is the glue between a host bridge that only issues 64-bit transfers on a local bus and an 8-bit boot flash on that bus. Normally the local processor owns the bus: the block passes the processor's flash chip select and flash address straight through to the device, and all eight byte lanes stay enabled.

When the host pulls the active-low mode request line to 0, the block enters a flash mode. It first puts the processor into hard reset and releases the processor's bus drivers to high impedance. It waits a settle interval with the processor held in reset. Only then does it park the bus for the host bridge and switch the address path. In flash mode the three lowest flash byte-address bits come from host address bits 24:22. Every byte of the flash can then be reached through byte lane 0 at 8-byte-aligned host addresses. The block also decodes its own chip select from a host address window, because the processor's chip-select logic is dead while the processor is in reset. A ready status tells host software when it may start flash accesses.

Releasing the request line reverses the sequence. Park, remap and ready drop together. The processor is then kept in reset for a minimum hold interval before it is let go.

Top module: `flash_mode_bridge`

## Requirements
- R1: The mode request passes through two synchronizing flops. A change on `mode_req_n` becomes visible on the outputs after the third rising clock edge that follows it.
- R2: `cpu_hreset_n` is 0 in every cycle in which `bus_park_host` or `flash_mode_ready` is 1.
- R3: `cpu_pins_hiz` is 1 in every cycle in which `cpu_hreset_n` is 0. Out of reset, `cpu_pins_hiz`, `bus_park_host` and `flash_mode_ready` are 0 and `cpu_hreset_n` is 1.
- R4: In flash mode, `flash_addr[2:0]` equals `host_addr[24:22]` and `flash_addr[FADDR_W-1:3]` equals `host_addr[FADDR_W-1:3]`.
- R5: `flash_lane_en` is 8'b0000_0001 (byte lane 0 only, data bits 7:0) in flash mode and 8'hFF in every other cycle.
- R6: On entry, reset is asserted first. Park and ready rise exactly SETTLE_CYC cycles later; a value below 4 counts as 4.
- R7: On exit, park, remap and ready all drop on the same edge while reset stays asserted. Reset is released exactly HOLD_CYC cycles after that edge.
- R8: In flash mode, `flash_cs_n` is 0 exactly when `host_cyc` is 1 and (`{host_addr,3'b000}` & WIN_MASK) equals WIN_BASE.
- R9: In normal mode, `flash_addr` equals `cpu_addr` and `flash_cs_n` equals `cpu_flash_cs_n`.
- R10: While entering or leaving flash mode, `flash_cs_n` is 1 whatever the processor or the host drives.
- R11: `flash_mode_ready` is 1 exactly in the cycles in which flash mode is fully established, the same cycles in which `bus_park_host` is 1.
- R12: If the request is withdrawn before the settle interval ends, the bus is never parked. The processor still sees the full hold interval of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_n | input | 1 | Asynchronous flash mode request, active low |
| host_addr | input | HADDR_W-3 | Host 8-byte-aligned address, bits HADDR_W-1:3 |
| host_cyc | input | 1 | Host bridge has a bus cycle in progress |
| cpu_addr | input | FADDR_W | Processor flash byte address |
| cpu_flash_cs_n | input | 1 | Processor flash chip select, active low |
| cpu_hreset_n | output | 1 | Processor hard reset, active low |
| cpu_pins_hiz | output | 1 | Forces processor bus drivers to high impedance |
| bus_park_host | output | 1 | Local bus parked for the host bridge |
| flash_addr | output | FADDR_W | Flash byte address |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_lane_en | output | 8 | Byte lane enables for the 64-bit data bus |
| flash_mode_ready | output | 1 | Flash mode fully established |

## Verification
The hardest case to reach is a request withdrawn partway through the settle interval. In that window reset is already asserted but the bus has not yet been parked. The exit path must then still give the full reset hold without ever granting the bus. The bench reaches this case by asserting the request and counting edges through the synchronizer delay. It releases the request two cycles into the settle interval, then watches park and reset on every cycle until the processor comes out of reset. The exact-cycle checks on entry and exit use the same edge counting, so the settle and hold lengths are pinned to the cycle.

// File: rtl/fmb_pkg.sv
package fmb_pkg;

    typedef enum logic [1:0] {
        FMB_NORMAL = 2'd0,
        FMB_ENTER  = 2'd1,
        FMB_FLASH  = 2'd2,
        FMB_EXIT   = 2'd3
    } fmb_state_e;

    typedef struct packed {
        logic hreset_n;
        logic pins_hiz;
        logic park;
        logic remap;
        logic ready;
        logic xfer_block;
    } fmb_ctl_t;

    localparam int FMB_MIN_SETTLE = 4;
    localparam logic [7:0] FMB_LANE0 = 8'h01;
    localparam logic [7:0] FMB_LANES = 8'hFF;

    function automatic fmb_ctl_t fmb_decode(fmb_state_e st);
        fmb_ctl_t c;
        c.hreset_n   = (st == FMB_NORMAL);
        c.pins_hiz   = (st != FMB_NORMAL);
        c.park       = (st == FMB_FLASH);
        c.remap      = (st == FMB_FLASH);
        c.ready      = (st == FMB_FLASH);
        c.xfer_block = (st == FMB_ENTER) || (st == FMB_EXIT);
        return c;
    endfunction

endpackage

// File: rtl/fmb_sync.sv
module fmb_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fmb_seq.sv
module fmb_seq
    import fmb_pkg::*;
#(
    parameter int SETTLE_CYC = 6,
    parameter int HOLD_CYC   = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    output fmb_ctl_t ctl
);
    localparam int SETTLE_EFF = (SETTLE_CYC < FMB_MIN_SETTLE) ? FMB_MIN_SETTLE : SETTLE_CYC;
    localparam int HOLD_EFF   = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int CNT_MAX    = (SETTLE_EFF > HOLD_EFF) ? SETTLE_EFF : HOLD_EFF;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_EFF - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_EFF - 1);

    fmb_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = '0;
        unique case (state)
            FMB_NORMAL: if (req) state_nx = FMB_ENTER;
            FMB_ENTER: begin
                if (!req)                    state_nx = FMB_EXIT;
                else if (cnt == SETTLE_LAST) state_nx = FMB_FLASH;
                else                         cnt_nx   = cnt + 1'b1;
            end
            FMB_FLASH: if (!req) state_nx = FMB_EXIT;
            FMB_EXIT: begin
                if (cnt == HOLD_LAST) state_nx = FMB_NORMAL;
                else                  cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = FMB_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FMB_NORMAL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign ctl = fmb_decode(state);
endmodule

// File: rtl/fmb_remap.sv
module fmb_remap
    import fmb_pkg::*;
#(
    parameter int HADDR_W = 32,
    parameter int FADDR_W = 22,
    parameter int REMAP_LSB = 22,
    parameter logic [HADDR_W-1:0] WIN_BASE = 32'hFE00_0000,
    parameter logic [HADDR_W-1:0] WIN_MASK = 32'hFE00_0000
) (
    input  fmb_ctl_t             ctl,
    input  logic [HADDR_W-1:3]   host_addr,
    input  logic                 host_cyc,
    input  logic [FADDR_W-1:0]   cpu_addr,
    input  logic                 cpu_flash_cs_n,
    output logic [FADDR_W-1:0]   flash_addr,
    output logic                 flash_cs_n,
    output logic [7:0]           flash_lane_en
);
    logic [HADDR_W-1:0] host_full;
    logic               in_window;
    logic [FADDR_W-1:0] remapped;

    assign host_full = {host_addr, 3'b000};
    assign in_window = ((host_full & WIN_MASK) == WIN_BASE);
    assign remapped  = {host_addr[FADDR_W-1:3], host_addr[REMAP_LSB+2:REMAP_LSB]};

    always_comb begin
        if (ctl.remap) begin
            flash_addr    = remapped;
            flash_cs_n    = !(host_cyc && in_window);
            flash_lane_en = FMB_LANE0;
        end else if (ctl.xfer_block) begin
            flash_addr    = cpu_addr;
            flash_cs_n    = 1'b1;
            flash_lane_en = FMB_LANES;
        end else begin
            flash_addr    = cpu_addr;
            flash_cs_n    = cpu_flash_cs_n;
            flash_lane_en = FMB_LANES;
        end
    end
endmodule

// File: rtl/flash_mode_bridge.sv
module flash_mode_bridge
    import fmb_pkg::*;
#(
    parameter int HADDR_W    = 32,
    parameter int FADDR_W    = 22,
    parameter int SETTLE_CYC = 6,
    parameter int HOLD_CYC   = 10,
    parameter logic [HADDR_W-1:0] WIN_BASE = 32'hFE00_0000,
    parameter logic [HADDR_W-1:0] WIN_MASK = 32'hFE00_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_req_n,
    input  logic [HADDR_W-1:3]   host_addr,
    input  logic                 host_cyc,
    input  logic [FADDR_W-1:0]   cpu_addr,
    input  logic                 cpu_flash_cs_n,
    output logic                 cpu_hreset_n,
    output logic                 cpu_pins_hiz,
    output logic                 bus_park_host,
    output logic [FADDR_W-1:0]   flash_addr,
    output logic                 flash_cs_n,
    output logic [7:0]           flash_lane_en,
    output logic                 flash_mode_ready
);
    localparam int REMAP_LSB = 22;

    logic     req_n_sync;
    fmb_ctl_t ctl;

    fmb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (mode_req_n),
        .q_sync  (req_n_sync)
    );

    fmb_seq #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk (clk),
        .rst (rst),
        .req (!req_n_sync),
        .ctl (ctl)
    );

    fmb_remap #(
        .HADDR_W   (HADDR_W),
        .FADDR_W   (FADDR_W),
        .REMAP_LSB (REMAP_LSB),
        .WIN_BASE  (WIN_BASE),
        .WIN_MASK  (WIN_MASK)
    ) u_remap (
        .ctl            (ctl),
        .host_addr      (host_addr),
        .host_cyc       (host_cyc),
        .cpu_addr       (cpu_addr),
        .cpu_flash_cs_n (cpu_flash_cs_n),
        .flash_addr     (flash_addr),
        .flash_cs_n     (flash_cs_n),
        .flash_lane_en  (flash_lane_en)
    );

    assign cpu_hreset_n     = ctl.hreset_n;
    assign cpu_pins_hiz     = ctl.pins_hiz;
    assign bus_park_host    = ctl.park;
    assign flash_mode_ready = ctl.ready;
endmodule

// File: rtl/fmb_checker.sv
module fmb_checker #(
    parameter int HOLD_CYC = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       cpu_hreset_n,
    input logic       cpu_pins_hiz,
    input logic       bus_park_host,
    input logic       flash_cs_n,
    input logic [7:0] flash_lane_en,
    input logic       flash_mode_ready
);
    localparam int HOLD_EFF = (HOLD_CYC < 1) ? 1 : HOLD_CYC;

    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || cpu_hreset_n || bus_park_host) low_cnt <= '0;
        else if (low_cnt != 16'hFFFF)             low_cnt <= low_cnt + 1'b1;
    end

    a_r2_reset_under_park: assert property (@(posedge clk) disable iff (rst)
        (bus_park_host || flash_mode_ready) |-> !cpu_hreset_n);

    a_r3_hiz_in_reset: assert property (@(posedge clk) disable iff (rst)
        !cpu_hreset_n |-> cpu_pins_hiz);

    a_r11_ready_is_park: assert property (@(posedge clk) disable iff (rst)
        flash_mode_ready == bus_park_host);

    a_r5_lane_zero: assert property (@(posedge clk) disable iff (rst)
        flash_mode_ready |-> (flash_lane_en == 8'h01));

    a_r6_settle_before_park: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_park_host) |-> (!$past(cpu_hreset_n) && low_cnt >= 16'd4));

    a_r7_hold_before_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_hreset_n) |-> ($past(!bus_park_host) && low_cnt >= 16'(HOLD_EFF)));

    a_r10_no_cs_in_transition: assert property (@(posedge clk) disable iff (rst)
        (!cpu_hreset_n && !bus_park_host) |-> flash_cs_n);
endmodule

bind flash_mode_bridge fmb_checker #(.HOLD_CYC(HOLD_CYC)) u_fmb_checker (
    .clk              (clk),
    .rst              (rst),
    .cpu_hreset_n     (cpu_hreset_n),
    .cpu_pins_hiz     (cpu_pins_hiz),
    .bus_park_host    (bus_park_host),
    .flash_cs_n       (flash_cs_n),
    .flash_lane_en    (flash_lane_en),
    .flash_mode_ready (flash_mode_ready)
);

// File: tb/sim_flash_mode_bridge.sv
module sim_flash_mode_bridge;
    localparam int HADDR_W = 32;
    localparam int FADDR_W = 22;
    localparam int SETTLE  = 6;
    localparam int HOLD    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_req_n = 1'b1;
    logic [HADDR_W-1:3] host_addr = '0;
    logic host_cyc = 1'b0;
    logic [FADDR_W-1:0] cpu_addr = '0;
    logic cpu_flash_cs_n = 1'b1;
    logic cpu_hreset_n, cpu_pins_hiz, bus_park_host, flash_cs_n, flash_mode_ready;
    logic [FADDR_W-1:0] flash_addr;
    logic [7:0] flash_lane_en;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    flash_mode_bridge #(.HADDR_W(HADDR_W), .FADDR_W(FADDR_W),
                        .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst), .mode_req_n(mode_req_n),
        .host_addr(host_addr), .host_cyc(host_cyc),
        .cpu_addr(cpu_addr), .cpu_flash_cs_n(cpu_flash_cs_n),
        .cpu_hreset_n(cpu_hreset_n), .cpu_pins_hiz(cpu_pins_hiz),
        .bus_park_host(bus_park_host), .flash_addr(flash_addr),
        .flash_cs_n(flash_cs_n), .flash_lane_en(flash_lane_en),
        .flash_mode_ready(flash_mode_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R3 reset hreset_n", 64'(cpu_hreset_n), 64'd1);
        chk("R3 reset hiz", 64'(cpu_pins_hiz), 64'd0);
        chk("R3 reset park", 64'(bus_park_host), 64'd0);
        chk("R11 reset ready", 64'(flash_mode_ready), 64'd0);
        chk("R5 reset lanes", 64'(flash_lane_en), 64'hFF);
    endtask

    task automatic t_normal;
        cpu_addr = 22'h2A_5A5B; cpu_flash_cs_n = 1'b0;
        host_addr = 29'h1FC0_0001; host_cyc = 1'b1;
        #1;
        chk("R9 pass addr", 64'(flash_addr), 64'h2A_5A5B);
        chk("R9 pass cs", 64'(flash_cs_n), 64'd0);
        cpu_addr = 22'h01_0007; cpu_flash_cs_n = 1'b1;
        #1;
        chk("R9 pass addr 2", 64'(flash_addr), 64'h01_0007);
        chk("R9 pass cs high", 64'(flash_cs_n), 64'd1);
        host_cyc = 1'b0;
    endtask

    task automatic t_entry;
        cpu_flash_cs_n = 1'b0;
        @(negedge clk);
        mode_req_n = 1'b0;
        edges(2);
        chk("R1 still normal after 2 edges", 64'(cpu_hreset_n), 64'd1);
        edges(1);
        chk("R1 reset on 3rd edge", 64'(cpu_hreset_n), 64'd0);
        chk("R3 hiz in reset", 64'(cpu_pins_hiz), 64'd1);
        chk("R6 no park yet", 64'(bus_park_host), 64'd0);
        chk("R10 cs blocked entering", 64'(flash_cs_n), 64'd1);
        edges(SETTLE - 1);
        chk("R6 not ready before settle", 64'(flash_mode_ready), 64'd0);
        edges(1);
        chk("R6 park after settle", 64'(bus_park_host), 64'd1);
        chk("R11 ready", 64'(flash_mode_ready), 64'd1);
        chk("R2 reset held", 64'(cpu_hreset_n), 64'd0);
        chk("R5 lane 0 only", 64'(flash_lane_en), 64'h01);
        cpu_flash_cs_n = 1'b1;
    endtask

    task automatic t_remap;
        logic [31:0] ha;
        logic [31:0] addrs [4];
        addrs[0] = 32'hFE00_0000; addrs[1] = 32'hFFC0_0008;
        addrs[2] = 32'hFE5A_5A50; addrs[3] = 32'hFF9F_FFF8;
        for (int i = 0; i < 4; i++) begin
            ha = addrs[i];
            host_addr = ha[31:3]; host_cyc = 1'b1;
            #1;
            chk("R4 remap addr", 64'(flash_addr), 64'({ha[21:3], ha[24:22]}));
            chk("R8 cs in window", 64'(flash_cs_n), 64'd0);
        end
        ha = 32'h7E00_0000; host_addr = ha[31:3];
        #1;
        chk("R8 cs outside window", 64'(flash_cs_n), 64'd1);
        ha = 32'hFE00_0040; host_addr = ha[31:3]; host_cyc = 1'b0;
        cpu_flash_cs_n = 1'b0;
        #1;
        chk("R8 cs no host cycle", 64'(flash_cs_n), 64'd1);
        cpu_flash_cs_n = 1'b1;
    endtask

    task automatic t_exit;
        host_cyc = 1'b1;
        @(negedge clk);
        mode_req_n = 1'b1;
        edges(2);
        chk("R1 still flash after 2 edges", 64'(flash_mode_ready), 64'd1);
        edges(1);
        chk("R7 park dropped", 64'(bus_park_host), 64'd0);
        chk("R7 ready dropped", 64'(flash_mode_ready), 64'd0);
        chk("R7 reset kept", 64'(cpu_hreset_n), 64'd0);
        chk("R10 cs blocked leaving", 64'(flash_cs_n), 64'd1);
        chk("R5 lanes restored", 64'(flash_lane_en), 64'hFF);
        edges(HOLD - 1);
        chk("R7 reset through hold", 64'(cpu_hreset_n), 64'd0);
        edges(1);
        chk("R7 reset released", 64'(cpu_hreset_n), 64'd1);
        chk("R3 hiz released", 64'(cpu_pins_hiz), 64'd0);
        host_cyc = 1'b0;
        cpu_addr = 22'h33_1234; cpu_flash_cs_n = 1'b0;
        #1;
        chk("R9 pass after exit", 64'(flash_addr), 64'h33_1234);
        chk("R9 cs after exit", 64'(flash_cs_n), 64'd0);
        cpu_flash_cs_n = 1'b1;
    endtask

    task automatic t_abort;
        int parked = 0;
        int low = 0;
        @(negedge clk);
        mode_req_n = 1'b0;
        edges(5);
        chk("R12 in settle", 64'(cpu_hreset_n), 64'd0);
        mode_req_n = 1'b1;
        for (int i = 0; i < 40 && !cpu_hreset_n; i++) begin
            if (bus_park_host) parked++;
            low++;
            edges(1);
        end
        chk("R12 never parked", 64'(parked), 64'd0);
        chk("R12 reset back high", 64'(cpu_hreset_n), 64'd1);
        chk("R12 full hold kept", 64'(low >= HOLD + 3), 64'd1);
    endtask

    initial begin
        fork
            begin
                edges(3);
                rst = 1'b0;
                edges(1);
                t_reset;
                t_normal;
                t_entry;
                t_remap;
                t_exit;
                t_abort;
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule